// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking a four-level radix page table in memory. The 48 significant address bits are split into four 9-bit table indices and a 12-bit page offset. A walk starts at a root table frame given with the request. At each level the walker reads one 64-bit entry and follows it to the next table. The walk ends at a leaf: a 4 KB page at the lowest level, or a 2 MB or 1 GB large page one or two levels higher. It can also end on a fault.

A request carries the virtual address, the root frame number, an access kind and a user/kernel flag. Requests are valid/ready. The requester holds `req_valid` and the request fields stable until `req_ready` is seen high at a clock edge. `req_ready` is high only while the walker is idle.

Memory reads leave on a valid/ready port. The walker holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`. Only one read is ever outstanding. The response port has no ready: memory returns exactly one `mem_rsp_valid` beat per accepted read, after any delay of at least one cycle.

The result is a single-cycle pulse with no back-pressure. It carries a fault code, the physical address, a page-size code and the attribute bits of the leaf entry. Write and user permission are ANDed over every level walked.

Top module: `pgwalk_top`

## Requirements
- R1: A request whose bits 63:48 do not all equal bit 47 is accepted and answered in the next cycle with fault code 5 (non-canonical), and no memory read is issued for it.
- R2: Each entry read is at byte address {table frame, 9-bit index, 3'b000}. The top table frame is `req_root_frame`, and each lower table frame is bits 51:12 of the entry above. The indices come from virtual bits 47:39, 38:30, 29:21 and 20:12, from the top level down.
- R3: An entry with bit 0 clear ends the walk at once with fault code 1 (not present), and no further read is made.
- R4: At the third level (index from bits 38:30), an entry with bit 7 set ends the walk as a 1 GB page. The size code is 2 and the physical address is {entry[51:30], vaddr[29:0]}.
- R5: At the second level (index from bits 29:21), an entry with bit 7 set ends the walk as a 2 MB page. The size code is 1 and the physical address is {entry[51:21], vaddr[20:0]}.
- R6: A lowest-level entry is always a 4 KB leaf, with size code 0 and physical address {entry[51:12], vaddr[11:0]}. Bit 7 in a top-level or lowest-level entry does not end or alter the walk.
- R7: A write access (`req_access` = 1) faults with code 2 when bit 1 is clear in any entry walked. When every entry walked has bit 1 set, the write succeeds.
- R8: A user access (`req_user` = 1) faults with code 3 when bit 2 is clear in any entry walked. This code takes priority over code 2.
- R9: A fetch (`req_access` = 2) to a leaf whose bit 63 is set faults with code 4. This check ranks after codes 3 and 2. Bit 63 has no effect on reads (`req_access` = 0) or on writes.
- R10: `req_ready` is low from acceptance until the walk finishes. `res_valid` is high for exactly one cycle per request. Fault code 0 means success.
- R11: On success, `res_attr` carries leaf entry bits 63:52 in its upper 12 bits and leaf entry bits 11:0 in its lower 12 bits.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged. Each level is read exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted at this edge |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root_frame | input | 40 | Frame number of the top-level table |
| req_access | input | 2 | 0 read, 1 write, 2 fetch (3 acts as read) |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Entry read request present |
| mem_req_ready | input | 1 | Memory takes the read at this edge |
| mem_req_addr | output | 52 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Entry data returned (one beat per read) |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault_code | output | 3 | 0 ok, 1 not present, 2 write, 3 user, 4 no-exec, 5 non-canonical |
| res_paddr | output | 52 | Physical address (on success) |
| res_size | output | 2 | 0 4 KB, 1 2 MB, 2 1 GB (on success) |
| res_attr | output | 24 | Leaf entry bits {63:52, 11:0} (on success) |

## Verification
The assertions assume that memory raises `mem_rsp_valid` only while a read it has accepted is pending, and only once per such read. They also assume that a requester never changes its fields in a cycle where `req_ready` is low. The bench memory model keeps to these rules. It takes a read only at an edge where both valid and ready are high. It drops `mem_req_ready` at random to exercise back-pressure. It replies once, after a random latency of one to four cycles. The driver starts a new request only after the previous result has been scored.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_NOT_PRESENT = 3'd1,
    FLT_WRITE       = 3'd2,
    FLT_USER        = 3'd3,
    FLT_NOEXEC      = 3'd4,
    FLT_NONCANON    = 3'd5
  } flt_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;

  localparam int ENT_W       = 64;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_LARGE   = 7;
  localparam int BIT_NOEXEC  = 63;

endpackage

// File: rtl/pgwalk_canon.sv
module pgwalk_canon #(
  parameter int VA_W = 48
) (
  input  logic [63:VA_W-1] upper_bits,
  output logic             canon_ok
);
  always_comb begin
    canon_ok = (&upper_bits) | ~(|upper_bits);
  end
endmodule

// File: rtl/pgwalk_index.sv
module pgwalk_index #(
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int SEL_W = IDX_W * LEVELS
) (
  input  logic [SEL_W-1:0] va_sel,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_by_lvl [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign idx_by_lvl[g] = va_sel[g*IDX_W +: IDX_W];
  end

  assign idx = idx_by_lvl[level];
endmodule

// File: rtl/pgwalk_pte_eval.sv
module pgwalk_pte_eval
  import pgwalk_pkg::*;
#(
  parameter int VA_W          = 48,
  parameter int PA_W          = 52,
  parameter int PG_SHIFT      = 12,
  parameter int IDX_W         = 9,
  parameter int LEVELS        = 4,
  parameter int MAX_LARGE_LVL = 2,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int PFN_W  = PA_W - PG_SHIFT,
  localparam int ATTR_W = ENT_W - PA_W + PG_SHIFT
) (
  input  logic [ENT_W-1:0]  entry,
  input  logic [LVL_W-1:0]  level,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [1:0]        access,
  input  logic              user,
  input  logic              wr_ok_in,
  input  logic              us_ok_in,
  output logic              terminal,
  output logic [2:0]        fault_code,
  output logic [PA_W-1:0]   paddr,
  output logic [1:0]        size_code,
  output logic [ATTR_W-1:0] attr,
  output logic              wr_ok_out,
  output logic              us_ok_out,
  output logic [PFN_W-1:0]  next_frame
);
  logic            present;
  logic            is_leaf;
  logic [PA_W-1:0] keep_mask;
  logic [PA_W-1:0] frame_pa;
  logic [PA_W-1:0] va_ext;
  int unsigned     off_w;

  always_comb begin
    present    = entry[BIT_PRESENT];
    wr_ok_out  = wr_ok_in & entry[BIT_WRITE];
    us_ok_out  = us_ok_in & entry[BIT_USER];
    is_leaf    = (level == '0) ||
                 (entry[BIT_LARGE] && (int'(level) <= MAX_LARGE_LVL));
    next_frame = entry[PA_W-1:PG_SHIFT];
    attr       = {entry[ENT_W-1:PA_W], entry[PG_SHIFT-1:0]};

    // Offset width grows by one index field per level above the leaf table.
    off_w     = PG_SHIFT + int'(level) * IDX_W;
    keep_mask = {PA_W{1'b1}} << off_w;
    frame_pa  = {next_frame, {PG_SHIFT{1'b0}}};
    va_ext    = {{(PA_W-VA_W){1'b0}}, vaddr};
    paddr     = (frame_pa & keep_mask) | (va_ext & ~keep_mask);
    size_code = 2'(level);

    terminal   = 1'b0;
    fault_code = FLT_NONE;
    if (!present) begin
      terminal   = 1'b1;
      fault_code = FLT_NOT_PRESENT;
    end else if (is_leaf) begin
      terminal = 1'b1;
      if (user && !us_ok_out)
        fault_code = FLT_USER;
      else if (access == ACC_WRITE && !wr_ok_out)
        fault_code = FLT_WRITE;
      else if (access == ACC_FETCH && entry[BIT_NOEXEC])
        fault_code = FLT_NOEXEC;
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W          = 48,
  parameter int PA_W          = 52,
  parameter int PG_SHIFT      = 12,
  parameter int IDX_W         = 9,
  parameter int LEVELS        = 4,
  parameter int MAX_LARGE_LVL = 2,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int PFN_W  = PA_W - PG_SHIFT,
  localparam int ATTR_W = ENT_W - PA_W + PG_SHIFT,
  localparam int ENT_SH = $clog2(ENT_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic [PFN_W-1:0]  req_root_frame,
  input  logic [1:0]        req_access,
  input  logic              req_user,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  output logic [2:0]        res_fault_code,
  output logic [PA_W-1:0]   res_paddr,
  output logic [1:0]        res_size,
  output logic [ATTR_W-1:0] res_attr
);
  walk_st_e         state;
  logic [LVL_W-1:0] level;
  logic [PFN_W-1:0] frame;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic             wr_ok_q;
  logic             us_ok_q;

  logic             accept;
  logic             canon_ok;
  logic [IDX_W-1:0] cur_idx;

  logic              ev_terminal;
  logic [2:0]        ev_code;
  logic [PA_W-1:0]   ev_paddr;
  logic [1:0]        ev_size;
  logic [ATTR_W-1:0] ev_attr;
  logic              ev_wr_ok;
  logic              ev_us_ok;
  logic [PFN_W-1:0]  ev_next;

  assign req_ready     = (state == ST_IDLE);
  assign accept        = req_valid & req_ready;
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = {frame, cur_idx, {ENT_SH{1'b0}}};

  pgwalk_canon #(.VA_W(VA_W)) u_canon (
    .upper_bits (req_vaddr[63:VA_W-1]),
    .canon_ok   (canon_ok)
  );

  pgwalk_index #(.IDX_W(IDX_W), .LEVELS(LEVELS)) u_index (
    .va_sel (va_q[VA_W-1:PG_SHIFT]),
    .level  (level),
    .idx    (cur_idx)
  );

  pgwalk_pte_eval #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .MAX_LARGE_LVL(MAX_LARGE_LVL)
  ) u_eval (
    .entry      (mem_rsp_data),
    .level      (level),
    .vaddr      (va_q),
    .access     (acc_q),
    .user       (user_q),
    .wr_ok_in   (wr_ok_q),
    .us_ok_in   (us_ok_q),
    .terminal   (ev_terminal),
    .fault_code (ev_code),
    .paddr      (ev_paddr),
    .size_code  (ev_size),
    .attr       (ev_attr),
    .wr_ok_out  (ev_wr_ok),
    .us_ok_out  (ev_us_ok),
    .next_frame (ev_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      level          <= '0;
      frame          <= '0;
      va_q           <= '0;
      acc_q          <= '0;
      user_q         <= 1'b0;
      wr_ok_q        <= 1'b0;
      us_ok_q        <= 1'b0;
      res_valid      <= 1'b0;
      res_fault_code <= '0;
      res_paddr      <= '0;
      res_size       <= '0;
      res_attr       <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            va_q    <= req_vaddr[VA_W-1:0];
            acc_q   <= req_access;
            user_q  <= req_user;
            frame   <= req_root_frame;
            level   <= LVL_W'(LEVELS - 1);
            wr_ok_q <= 1'b1;
            us_ok_q <= 1'b1;
            if (canon_ok) begin
              state <= ST_ISSUE;
            end else begin
              res_valid      <= 1'b1;
              res_fault_code <= FLT_NONCANON;
              res_paddr      <= '0;
              res_size       <= '0;
              res_attr       <= '0;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (ev_terminal) begin
              state          <= ST_IDLE;
              res_valid      <= 1'b1;
              res_fault_code <= ev_code;
              res_paddr      <= ev_paddr;
              res_size       <= ev_size;
              res_attr       <= ev_attr;
            end else begin
              frame   <= ev_next;
              level   <= level - 1'b1;
              wr_ok_q <= ev_wr_ok;
              us_ok_q <= ev_us_ok;
              state   <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a rejected address answers next cycle without touching memory
  assert_noncanon_noread_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !canon_ok) |=> (res_valid && res_fault_code == FLT_NONCANON && !mem_req_valid));

  // R12: a stalled read keeps its request and address
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: result is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10: no new request is taken while a read is in flight
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R7: a write fault only ever answers a write access
  assert_write_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault_code == FLT_WRITE) |-> (acc_q == ACC_WRITE));

  // R8: a user fault only ever answers a user access
  assert_user_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault_code == FLT_USER) |-> user_q);

  // R4: a successful result never carries an undefined size code
  assert_size_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault_code == FLT_NONE) |-> (res_size != 2'd3));
endmodule

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [39:0] req_root_frame = '0;
  logic [1:0]  req_access = '0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic [2:0]  res_fault_code;
  logic [51:0] res_paddr;
  logic [1:0]  res_size;
  logic [23:0] res_attr;

  always #4 clk = ~clk;

  pgwalk_top u_dut (.*);

  typedef struct {
    logic [2:0]  code;
    logic [51:0] pa;
    logic [1:0]  sz;
    logic [23:0] attr;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] mem [logic [51:0]];
  int          nchk = 0;
  int          nfail = 0;
  int          rd_cnt = 0;
  int          test_id = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // Memory model: random back-pressure, one reply per read after 1..4 cycles.
  initial begin
    bit          pend = 0;
    int          lat = 0;
    logic [51:0] pa = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(pa) ? mem[pa] : 64'h0;
          pend = 0;
        end else lat--;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      if (mem_req_valid && mem_req_ready && rst_n) begin
        pa = mem_req_addr;
        pend = 1;
        lat = $urandom_range(0, 3);
        rd_cnt++;
        chk(mem.exists(pa), "R2", "read address hits a built entry", {12'h0, pa}, 64'h0);
      end
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (res_valid) begin
        exp_t e;
        chk(!prev, "R10", "result pulse longer than one cycle", 64'(prev), 64'h0);
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected result", 64'(res_fault_code), 64'h0);
        end else begin
          e = exp_q.pop_front();
          chk(res_fault_code == e.code, e.tag, "fault code", 64'(res_fault_code), 64'(e.code));
          chk(rd_cnt == e.reads, e.tag, "read count", 64'(rd_cnt), 64'(e.reads));
          if (e.code == 3'd0) begin
            chk(res_paddr == e.pa, e.tag, "paddr", 64'(res_paddr), 64'(e.pa));
            chk(res_size == e.sz, e.tag, "size", 64'(res_size), 64'(e.sz));
            chk(res_attr == e.attr, "R11", "attributes", 64'(res_attr), 64'(e.attr));
          end
        end
      end
      prev = res_valid;
    end
  end

  task automatic send(input logic [63:0] va, input logic [39:0] root,
                      input logic [1:0] acc, input logic usr, input bit walk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_vaddr = va; req_root_frame = root;
    req_access = acc; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    if (walk) chk(req_ready == 1'b0, "R10", "ready low during walk", 64'(req_ready), 64'h0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Builds the table chain for one walk, queues the expected result, runs it.
  // Levels: 3 top, 2 (1 GB capable), 1 (2 MB capable), 0 lowest.
  task automatic run_walk(input string tag, input logic [63:0] va, input logic [1:0] acc,
                          input logic usr, input int leaf, input logic [3:0] pres,
                          input logic [3:0] wr, input logic [3:0] us, input logic nx,
                          input logic [39:0] leaf_frame, input logic [11:0] lowf,
                          input logic top_ps);
    logic [39:0] root;
    logic [63:0] e, leaf_e;
    logic [51:0] a;
    exp_t        x;
    bit          w = 1, u = 1;
    test_id++;
    root = 40'h1000 + 40'(test_id * 16);
    leaf_e = '0;
    x.code = 3'd0; x.reads = 0; x.tag = tag;
    for (int l = 3; l >= leaf; l--) begin
      e = '0;
      e[0] = pres[l]; e[1] = wr[l]; e[2] = us[l];
      if (l == leaf) begin
        e[51:12] = leaf_frame;
        e[6:3]   = lowf[6:3];
        e[11:8]  = lowf[11:8];
        e[7]     = (l > 0) ? 1'b1 : lowf[7];
        e[62:52] = 11'h5A3 ^ 11'(test_id);
        e[63]    = nx;
        leaf_e   = e;
      end else begin
        e[51:12] = root + 40'(4 - l);
        e[7]     = (l == 3) ? top_ps : 1'b0;
      end
      a = {root + 40'(3 - l), va[12 + 9*l +: 9], 3'b000};
      mem[a] = e;
    end
    for (int l = 3; l >= leaf; l--) begin
      x.reads++;
      if (!pres[l]) begin x.code = 3'd1; break; end
      w &= wr[l]; u &= us[l];
    end
    if (x.code == 3'd0) begin
      if (usr && !u) x.code = 3'd3;
      else if (acc == 2'd1 && !w) x.code = 3'd2;
      else if (acc == 2'd2 && nx) x.code = 3'd4;
    end
    case (leaf)
      0: x.pa = {leaf_frame, va[11:0]};
      1: x.pa = {leaf_frame[39:9], va[20:0]};
      default: x.pa = {leaf_frame[39:18], va[29:0]};
    endcase
    x.sz = 2'(leaf);
    x.attr = {leaf_e[63:52], leaf_e[11:0]};
    exp_q.push_back(x);
    send(va, root, acc, usr, 1);
  endtask

  task automatic run_noncanon(input logic [63:0] va);
    exp_t x;
    x.code = 3'd5; x.pa = '0; x.sz = '0; x.attr = '0; x.reads = 0; x.tag = "R1";
    exp_q.push_back(x);
    send(va, 40'h77, 2'd0, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 64'h0, 64'h0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", 64'(req_ready), 64'h1);
    chk(res_valid == 1'b0, "R10", "reset result", 64'(res_valid), 64'h0);
    chk(mem_req_valid == 1'b0, "R2", "reset read", 64'(mem_req_valid), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 / R2: plain 4 KB read, kernel
    run_walk("R6", 64'h0000_1234_5678_9ABC, 2'd0, 0, 0, 4'hF, 4'hF, 4'hF, 0, 40'hABCDE, 12'h168, 0);
    // R6: bit 7 on top-level and lowest-level entries does not change a 4 KB walk
    run_walk("R6", 64'h0000_7F00_00AB_C123, 2'd0, 0, 0, 4'hF, 4'hF, 4'hF, 0, 40'h13579, 12'h0F8, 1);
    // R5: 2 MB page at the second level, frame low bits masked off
    run_walk("R5", 64'h0000_0040_1F3C_DE01, 2'd0, 0, 1, 4'hF, 4'hF, 4'hF, 0, 40'h2_46FF, 12'h020, 0);
    // R4: 1 GB page at the third level
    run_walk("R4", 64'h0000_0123_7654_3210, 2'd0, 0, 2, 4'hF, 4'hF, 4'hF, 0, 40'h8_FFFFF, 12'h108, 0);
    // R1: sign-extended upper half walks normally
    run_walk("R1", 64'hFFFF_8000_1234_5678, 2'd0, 0, 0, 4'hF, 4'hF, 4'hF, 0, 40'h00042, 12'h000, 0);
    // R3: not present at the top, then at the lowest level
    run_walk("R3", 64'h0000_0000_0040_3000, 2'd0, 0, 0, 4'b0111, 4'hF, 4'hF, 0, 40'h1, 12'h0, 0);
    run_walk("R3", 64'h0000_0000_0040_3000, 2'd0, 0, 0, 4'b1110, 4'hF, 4'hF, 0, 40'h1, 12'h0, 0);
    // R7: read-only at an intermediate level blocks a write; all-writable succeeds
    run_walk("R7", 64'h0000_0ABC_DEF0_1000, 2'd1, 0, 0, 4'hF, 4'b1011, 4'hF, 0, 40'h55, 12'h0, 0);
    run_walk("R7", 64'h0000_0ABC_DEF0_1000, 2'd1, 0, 0, 4'hF, 4'hF, 4'hF, 0, 40'h56, 12'h040, 0);
    // R7: read of a read-only page succeeds
    run_walk("R7", 64'h0000_0ABC_DEF0_1000, 2'd0, 0, 1, 4'hF, 4'h0, 4'hF, 0, 40'h600, 12'h0, 0);
    // R8: supervisor-only at the top blocks user; user beats write fault
    run_walk("R8", 64'h0000_3000_0000_0000, 2'd0, 1, 0, 4'hF, 4'hF, 4'b0111, 0, 40'h9, 12'h0, 0);
    run_walk("R8", 64'h0000_3000_0000_0000, 2'd1, 1, 2, 4'hF, 4'b1011, 4'b1011, 0, 40'h9, 12'h0, 0);
    run_walk("R8", 64'h0000_3000_0000_0000, 2'd1, 1, 0, 4'hF, 4'hF, 4'hF, 0, 40'hA, 12'h0, 0);
    // R9: fetch of no-exec leaf faults; read and write of it do not; user beats no-exec
    run_walk("R9", 64'h0000_0000_DEAD_B000, 2'd2, 0, 0, 4'hF, 4'hF, 4'hF, 1, 40'hB, 12'h0, 0);
    run_walk("R9", 64'h0000_0000_DEAD_B000, 2'd0, 0, 0, 4'hF, 4'hF, 4'hF, 1, 40'hC, 12'h0, 0);
    run_walk("R9", 64'h0000_0000_DEAD_B000, 2'd1, 0, 1, 4'hF, 4'hF, 4'hF, 1, 40'hD00, 12'h0, 0);
    run_walk("R9", 64'h0000_0000_DEAD_B000, 2'd2, 1, 0, 4'hF, 4'hF, 4'b1101, 1, 40'hE, 12'h0, 0);
    // R1: non-canonical addresses, both polarities
    run_noncanon(64'h0001_0000_0000_0000);
    run_noncanon(64'hFFFF_0000_0000_1000);
    run_noncanon(64'h7FFF_8000_0000_0000);
    // R12: repeat walks under random back-pressure and latency
    for (int i = 0; i < 12; i++)
      run_walk("R12", {16'h0, 48'(i * 48'h0123_4567_89AB)}, 2'd0, 0, i % 3,
               4'hF, 4'hF, 4'hF, 0, 40'(40'h3_0000 + i * 777), 12'h000, 0);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule